// File: doc/BRIEF.md
# ADC Conversion Handshake Sequencer

This block runs a single conversion on an external eight-input, 8-bit analog-to-digital converter. When a start request arrives, the block takes a 3-bit channel number and drives it onto the converter's channel address lines. After a setup interval it sends a start-of-conversion pulse, which goes from low to high and back to low. It then polls the converter's end-of-conversion flag and stores the 8-bit result in a holding register. A one-cycle valid strobe reports the stored byte.

The end-of-conversion input passes through a two-stage synchroniser. For a programmable number of cycles after the pulse the block ignores it, so a flag left high by the previous conversion cannot be taken as the new result. The wait is bounded: if the flag never rises, a timeout ends the wait and the block reports an error strobe instead of data. The block ignores start requests while a conversion is in progress. The converter's output-enable and address-latch-enable are tied active outside this block, so the sequencer does not drive them.

Top module: `adc_seq_ctrl`

## Requirements
- R1: On an accepted start, `adc_addr` takes the binary value of `start_chan` (for example, channel 2 gives 3'b010). It keeps that value until the next accepted start. After reset it is 3'b000.
- R2: `adc_addr` is valid for exactly `SETUP_CYC` cycles with `adc_soc` low before `adc_soc` rises. It does not change while `adc_soc` is high.
- R3: Each accepted start gives exactly one `adc_soc` pulse. The pulse is high for exactly `PULSE_HI` consecutive cycles and then returns low.
- R4: `adc_eoc` is synchronised through two flip-flops. It is ignored while the pulse is high and for `BLANK_CYC` cycles after the pulse falls. A stale high that drops within that window does not produce a result.
- R5: When the synchronised flag is seen high after the blanking window, the block captures `adc_data` into `res_data` and raises `res_valid` for one cycle. The strobe appears on the third rising edge after `adc_eoc` rises. `res_data` holds its value until the next capture.
- R6: If the flag is not seen within `TIMEOUT_CYC` cycles after the blanking window, the block raises `timeout_err` for one cycle. This happens exactly `BLANK_CYC + TIMEOUT_CYC` cycles after the first cycle in which `adc_soc` is low again. In that case `res_valid` is not raised, and the block then accepts new starts.
- R7: A start request that arrives while a conversion is in progress has no effect: `adc_addr` does not change and no extra pulse is sent.
- R8: During and after reset, `adc_soc`, `res_valid` and `timeout_err` are low, and `res_data` and `adc_addr` are zero.
- R9: An end-of-conversion flag that arrives while the block is idle produces no `res_valid` and no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to begin a conversion, sampled when idle |
| start_chan | input | 3 | Channel to convert, taken with the request |
| adc_addr | output | 3 | Channel address to the converter |
| adc_soc | output | 1 | Start-of-conversion pulse to the converter |
| adc_eoc | input | 1 | End-of-conversion flag from the converter (asynchronous) |
| adc_data | input | 8 | Converter result byte |
| res_valid | output | 1 | One-cycle strobe: `res_data` holds a new result |
| res_data | output | 8 | Captured result byte |
| timeout_err | output | 1 | One-cycle strobe: the wait for end-of-conversion timed out |

## Verification
The bench counts cycles around the pulse: how long the address is set up before the pulse and how long the pulse stays high. A wrong setup or width count would shift the edge or stretch the pulse. It holds the flag high across a new start and drops it just inside the blanking window. A design without blanking would then return the stale byte early instead of the later one. The bench also measures the three-cycle latency from flag to strobe, the exact cycle of the timeout strobe, and a start request raised in the middle of a pulse. A design that re-accepted that request would change the address or send a second pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_BLANK = 3'd3,
    ST_WAIT  = 3'd4
  } seq_state_t;

  // Largest of the four phase lengths, used to size the shared counter.
  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Bits needed to hold values 0..maxv.
  function automatic int bits_for(input int maxv);
    int w;
    w = 1;
    while ((1 << w) <= maxv) w++;
    return w;
  endfunction

  // Reload value for a phase lasting len cycles.
  function automatic int phase_reload(input int len);
    return (len > 0) ? len - 1 : 0;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d_async;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (load) count <= load_val;
    else if (dec && (count != '0)) count <= count - 1'b1;
  end

  assign zero = (count == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_HI    = 4,
  parameter int BLANK_CYC   = 8,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [CH_W-1:0]   start_chan,
  output logic [CH_W-1:0]   adc_addr,
  output logic              adc_soc,
  input  logic              adc_eoc,
  input  logic [DATA_W-1:0] adc_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              timeout_err
);
  localparam int MAX_PHASE = max_of4(SETUP_CYC, PULSE_HI, BLANK_CYC, TIMEOUT_CYC);
  localparam int CNT_W     = bits_for(MAX_PHASE);
  localparam logic [CNT_W-1:0] RL_SETUP = CNT_W'(phase_reload(SETUP_CYC));
  localparam logic [CNT_W-1:0] RL_PULSE = CNT_W'(phase_reload(PULSE_HI));
  localparam logic [CNT_W-1:0] RL_BLANK = CNT_W'(phase_reload(BLANK_CYC));
  localparam logic [CNT_W-1:0] RL_WAIT  = CNT_W'(phase_reload(TIMEOUT_CYC));

  seq_state_t state_q, state_d;
  logic              tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;

  // Named internal events
  logic conv_accept, eoc_sync, capture_evt, timeout_evt, conv_busy;

  logic [CH_W-1:0]   addr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, err_q, soc_q;

  adc_seq_sync #(.STAGES(2)) u_eoc_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (adc_eoc),
    .q_sync  (eoc_sync)
  );

  adc_seq_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    conv_accept = 1'b0;
    capture_evt = 1'b0;
    timeout_evt = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          conv_accept = 1'b1;
          state_d     = ST_SETUP;
          tmr_load    = 1'b1;
          tmr_val     = RL_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = RL_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr_zero) begin
          state_d  = ST_BLANK;
          tmr_load = 1'b1;
          tmr_val  = RL_BLANK;
        end
      end
      ST_BLANK: begin
        if (tmr_zero) begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = RL_WAIT;
        end
      end
      ST_WAIT: begin
        if (eoc_sync) begin
          capture_evt = 1'b1;
          state_d     = ST_IDLE;
        end else if (tmr_zero) begin
          timeout_evt = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign conv_busy = (state_q != ST_IDLE);
  assign tmr_dec   = conv_busy && !tmr_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      soc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (conv_accept) addr_q <= start_chan;
      if (capture_evt) data_q <= adc_data;
      valid_q <= capture_evt;
      err_q   <= timeout_evt;
      soc_q   <= (state_d == ST_PULSE);
    end
  end

  assign adc_addr    = addr_q;
  assign adc_soc     = soc_q;
  assign res_valid   = valid_q;
  assign res_data    = data_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CH_W     = 3,
  parameter int PULSE_HI = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_req,
  input logic [CH_W-1:0] adc_addr,
  input logic            adc_soc,
  input logic            eoc_sync,
  input logic            conv_busy,
  input logic            res_valid,
  input logic            timeout_err
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else if (adc_soc) hi_run <= hi_run + 1'b1;
    else hi_run <= '0;
  end

  // R2: address steady across the rising edge and for the whole pulse
  a_r2_addr_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_soc |-> $stable(adc_addr));

  // R3: pulse width counted by the checker
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_soc) |-> (hi_run == 16'(PULSE_HI)));

  // R5: result strobe is one cycle and follows a seen flag
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r5_valid_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(eoc_sync));

  // R6: timeout and result never together, error is one cycle
  a_r6_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && timeout_err));
  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err);

  // R7: a request while busy leaves the address alone
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && start_req) |=> $stable(adc_addr));

  // R4: no result strobe while the pulse is high
  a_r4_no_valid_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_soc |-> !res_valid);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W), .PULSE_HI(PULSE_HI)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_req   (start_req),
  .adc_addr    (adc_addr),
  .adc_soc     (adc_soc),
  .eoc_sync    (eoc_sync),
  .conv_busy   (conv_busy),
  .res_valid   (res_valid),
  .timeout_err (timeout_err)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  localparam int SU = 2;
  localparam int PH = 4;
  localparam int BL = 6;
  localparam int TO = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic [2:0] start_chan = '0;
  logic [2:0] adc_addr;
  logic       adc_soc;
  logic       adc_eoc = 1'b0;
  logic [7:0] adc_data = '0;
  logic       res_valid;
  logic [7:0] res_data;
  logic       timeout_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.SETUP_CYC(SU), .PULSE_HI(PH), .BLANK_CYC(BL), .TIMEOUT_CYC(TO)) u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_chan(start_chan),
    .adc_addr(adc_addr), .adc_soc(adc_soc), .adc_eoc(adc_eoc), .adc_data(adc_data),
    .res_valid(res_valid), .res_data(res_data), .timeout_err(timeout_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue a start, measure setup and pulse; return at first negedge with soc low (n=0).
  task automatic run_pulse(input logic [2:0] ch, input bit inject, input logic [2:0] inj_ch);
    int lo_cnt = 0;
    int hi_cnt = 0;
    @(negedge clk);
    start_req = 1'b1; start_chan = ch;
    @(negedge clk);
    start_req = 1'b0;
    while (!adc_soc && lo_cnt < 50) begin
      check(adc_addr == ch, "R1", adc_addr, ch);
      lo_cnt++;
      @(negedge clk);
    end
    check(lo_cnt == SU, "R2", lo_cnt, SU);
    while (adc_soc && hi_cnt < 50) begin
      hi_cnt++;
      check(adc_addr == ch, "R2", adc_addr, ch);
      if (inject && hi_cnt == 2) begin start_req = 1'b1; start_chan = inj_ch; end
      else start_req = 1'b0;
      @(negedge clk);
    end
    start_req = 1'b0;
    check(hi_cnt == PH, "R3", hi_cnt, PH);
  endtask

  // From n=0, raise eoc at negedge d and expect the strobe three cycles later.
  task automatic finish_conv(input int d, input logic [7:0] val, input logic [2:0] ch);
    int k = 0;
    bit early = 0;
    for (int n = 1; n <= d; n++) begin
      @(negedge clk);
      if (res_valid || timeout_err || adc_soc) early = 1;
    end
    adc_eoc = 1'b1; adc_data = val;
    while (!res_valid && k < 20) begin @(negedge clk); k++; end
    check(!early, "R4", early, 0);
    check(k == 3, "R5", k, 3);
    check(res_data == val, "R5", res_data, val);
    check(adc_addr == ch, "R7", adc_addr, ch);
    @(negedge clk);
    adc_eoc = 1'b0;
    check(!res_valid, "R5", res_valid, 0);
    check(res_data == val, "R5", res_data, val);
  endtask

  task automatic t_reset;
    check(adc_soc == 0, "R8", adc_soc, 0);
    check(res_valid == 0, "R8", res_valid, 0);
    check(timeout_err == 0, "R8", timeout_err, 0);
    check(res_data == 0, "R8", res_data, 0);
    check(adc_addr == 0, "R8", adc_addr, 0);
  endtask

  task automatic t_basic(input logic [2:0] ch, input int d, input logic [7:0] val);
    run_pulse(ch, 0, 3'd0);
    finish_conv(d, val, ch);
  endtask

  task automatic t_stale;
    bit early = 0;
    int k = 0;
    adc_eoc = 1'b1; adc_data = 8'hAA;
    repeat (4) @(negedge clk);
    run_pulse(3'd6, 0, 3'd0);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (n == BL - 3) begin adc_eoc = 1'b0; adc_data = 8'h00; end
      if (res_valid) early = 1;
    end
    check(!early, "R4", early, 0);
    adc_eoc = 1'b1; adc_data = 8'h5C;
    while (!res_valid && k < 20) begin @(negedge clk); k++; end
    check(k == 3, "R4", k, 3);
    check(res_data == 8'h5C, "R4", res_data, 8'h5C);
    @(negedge clk);
    adc_eoc = 1'b0;
  endtask

  task automatic t_timeout;
    int first = -1;
    bit saw_valid = 0;
    int ecnt = 0;
    run_pulse(3'd1, 0, 3'd0);
    if (timeout_err) first = 0;
    for (int n = 1; n <= BL + TO + 5; n++) begin
      @(negedge clk);
      if (timeout_err) begin ecnt++; if (first < 0) first = n; end
      if (res_valid) saw_valid = 1;
    end
    check(first == BL + TO, "R6", first, BL + TO);
    check(ecnt == 1, "R6", ecnt, 1);
    check(!saw_valid, "R6", saw_valid, 0);
    t_basic(3'd4, BL + 1, 8'h3E);   // accepts a new start after timeout
  endtask

  task automatic t_busy;
    run_pulse(3'd3, 1, 3'd5);
    finish_conv(BL, 8'h77, 3'd3);
    t_basic(3'd5, BL + 2, 8'h19);
  endtask

  task automatic t_idle_eoc;
    bit seen = 0;
    adc_eoc = 1'b1; adc_data = 8'hE1;
    repeat (10) begin
      @(negedge clk);
      if (res_valid || adc_soc) seen = 1;
    end
    adc_eoc = 1'b0;
    repeat (3) @(negedge clk);
    check(!seen, "R9", seen, 0);
    check(res_data == 8'h19, "R9", res_data, 8'h19);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic(3'd2, BL + 2, 8'hC3);
    t_basic(3'd7, BL - 2, 8'h01);   // earliest accepted flag
    t_basic(3'd0, 20, 8'hFF);
    t_stale();
    t_timeout();
    t_busy();
    t_idle_eoc();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule